// File: doc/BRIEF.md
# DDR Input Capture Cell

This block is the capture stage of an input pad that carries double-data-rate traffic. One register samples the pad on every rising clock edge and a second register samples it on every falling edge. A realignment stage then presents each rising-edge bit together with the falling-edge bit that follows it, as one pair that changes on a single clock edge. That edge is fixed at build time to be either the rising or the falling edge. The logic that uses the pair then sees two bits that are valid in one clock domain.

Every register in the cell takes a single asynchronous control line, which is active high. The build-time power-up level decides what this line does. With a low level it clears every register, and with a high level it presets every register. A synchronous reset is also provided. It loads the same power-up level into each register, but only at that register's own active edge. The pad can be several bits wide, and each bit lane is captured on its own.

Top module: `ddr_in_capture`

## Requirements
- R1: When built for rising alignment, take a_k as the pad value sampled at rising edge k and b_k as the value sampled at the falling edge that follows it. Just after rising edge k+1, data_hi equals a_k and data_lo equals b_k, for every bit lane.
- R2: When built for falling alignment, take the same a_k and b_k. Just after the falling edge that follows rising edge k+1, data_hi equals a_k and data_lo equals b_k.
- R3: The outputs change only on the alignment edge. Across the other clock edge, data_hi and data_lo keep their values.
- R4: With the power-up level low, raising async_ctl drives data_hi and data_lo to all zeros at once, with no clock edge needed.
- R5: With the power-up level high, raising async_ctl drives data_hi and data_lo to all ones at once, with no clock edge needed.
- R6: While async_ctl is high, the outputs stay at the power-up level across clock edges, whatever values pad_d and sync_rst take.
- R7: Raising sync_rst leaves the outputs unchanged until an edge arrives. From the first alignment edge at which sync_rst is sampled high, the outputs show the power-up level (all zeros for low, all ones for high) and keep it while sync_rst stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; data is sampled on both of its edges |
| async_ctl | input | 1 | Active-high asynchronous clear or preset, shared by every register |
| sync_rst | input | 1 | Active-high synchronous reset to the power-up level |
| pad_d | input | WIDTH | Double-rate pad data |
| data_hi | output | WIDTH | Bit captured on the rising edge of the pair |
| data_lo | output | WIDTH | Bit captured on the falling edge of the pair |

## Verification
The bench builds two copies of the cell with WIDTH set to 4, and both are fed by the same pad, clock and control lines. The first copy uses rising alignment with a low power-up level. The second uses falling alignment with a high power-up level. Between them they cover both realignment variants and both polarities of the shared asynchronous line. Because the two copies have different reset levels, the bench can also tell a clear from a preset in the same test. The bench drives streams of distinct per-lane patterns, a synchronous reset applied in the middle of a stream, and an asynchronous pulse held across clock edges while sync_rst is high. Through these it exercises pair alignment, stability across the other edge, and the order of precedence between the two resets.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

    // Edge on which the realigned pair is presented
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } align_edge_e;

    // Level the registers take after configuration, clear or preset
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } pwr_lvl_e;

    // Which clock edge a storage element responds to
    typedef enum logic {
        CLK_POS = 1'b0,
        CLK_NEG = 1'b1
    } clk_sense_e;

    function automatic logic lvl_bit(pwr_lvl_e lvl);
        return (lvl == LVL_HIGH);
    endfunction

    function automatic clk_sense_e align_sense(align_edge_e ae);
        return (ae == EDGE_FALL) ? CLK_NEG : CLK_POS;
    endfunction

endpackage

// File: rtl/ddr_cell_reg.sv
module ddr_cell_reg
    import ddr_cap_pkg::*;
#(
    parameter int         WIDTH = 4,
    parameter pwr_lvl_e   LEVEL = LVL_LOW,
    parameter clk_sense_e SENSE = CLK_POS
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             srst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] INIT_WORD = {WIDTH{lvl_bit(LEVEL)}};

    generate
        if (SENSE == CLK_NEG) begin : g_neg
            always_ff @(negedge clk or posedge arst) begin
                if (arst) begin
                    q <= INIT_WORD;
                end else if (srst) begin
                    q <= INIT_WORD;
                end else begin
                    q <= d;
                end
            end
        end else begin : g_pos
            always_ff @(posedge clk or posedge arst) begin
                if (arst) begin
                    q <= INIT_WORD;
                end else if (srst) begin
                    q <= INIT_WORD;
                end else begin
                    q <= d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ddr_realign.sv
module ddr_realign
    import ddr_cap_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter pwr_lvl_e    LEVEL = LVL_LOW,
    parameter align_edge_e ALIGN = EDGE_RISE
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             srst,
    input  logic [WIDTH-1:0] rise_bits,
    input  logic [WIDTH-1:0] fall_bits,
    output logic [WIDTH-1:0] out_hi,
    output logic [WIDTH-1:0] out_lo
);

    localparam clk_sense_e OUT_SENSE = align_sense(ALIGN);

    logic [WIDTH-1:0] early_bit;

    generate
        if (ALIGN == EDGE_FALL) begin : g_hold
            // The rising-edge bit is replaced on the next rising edge, before
            // the falling edge that pairs it. Hold it across the high phase.
            ddr_cell_reg #(
                .WIDTH (WIDTH),
                .LEVEL (LEVEL),
                .SENSE (CLK_NEG)
            ) u_hold (
                .clk  (clk),
                .arst (arst),
                .srst (srst),
                .d    (rise_bits),
                .q    (early_bit)
            );
        end else begin : g_direct
            // The rising-edge bit is still in place when the next rising edge
            // arrives, so no holding element is needed.
            assign early_bit = rise_bits;
        end
    endgenerate

    ddr_cell_reg #(
        .WIDTH (WIDTH),
        .LEVEL (LEVEL),
        .SENSE (OUT_SENSE)
    ) u_out_hi (
        .clk  (clk),
        .arst (arst),
        .srst (srst),
        .d    (early_bit),
        .q    (out_hi)
    );

    ddr_cell_reg #(
        .WIDTH (WIDTH),
        .LEVEL (LEVEL),
        .SENSE (OUT_SENSE)
    ) u_out_lo (
        .clk  (clk),
        .arst (arst),
        .srst (srst),
        .d    (fall_bits),
        .q    (out_lo)
    );

endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture
    import ddr_cap_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter pwr_lvl_e    LEVEL = LVL_LOW,
    parameter align_edge_e ALIGN = EDGE_RISE
) (
    input  logic             clk,
    input  logic             async_ctl,
    input  logic             sync_rst,
    input  logic [WIDTH-1:0] pad_d,
    output logic [WIDTH-1:0] data_hi,
    output logic [WIDTH-1:0] data_lo
);

    logic [WIDTH-1:0] cap_rise;
    logic [WIDTH-1:0] cap_fall;

    ddr_cell_reg #(
        .WIDTH (WIDTH),
        .LEVEL (LEVEL),
        .SENSE (CLK_POS)
    ) u_cap_rise (
        .clk  (clk),
        .arst (async_ctl),
        .srst (sync_rst),
        .d    (pad_d),
        .q    (cap_rise)
    );

    ddr_cell_reg #(
        .WIDTH (WIDTH),
        .LEVEL (LEVEL),
        .SENSE (CLK_NEG)
    ) u_cap_fall (
        .clk  (clk),
        .arst (async_ctl),
        .srst (sync_rst),
        .d    (pad_d),
        .q    (cap_fall)
    );

    ddr_realign #(
        .WIDTH (WIDTH),
        .LEVEL (LEVEL),
        .ALIGN (ALIGN)
    ) u_realign (
        .clk       (clk),
        .arst      (async_ctl),
        .srst      (sync_rst),
        .rise_bits (cap_rise),
        .fall_bits (cap_fall),
        .out_hi    (data_hi),
        .out_lo    (data_lo)
    );

endmodule

// File: rtl/ddr_in_capture_chk.sv
module ddr_in_capture_chk
    import ddr_cap_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter pwr_lvl_e    LEVEL = LVL_LOW,
    parameter align_edge_e ALIGN = EDGE_RISE
) (
    input logic             clk,
    input logic             async_ctl,
    input logic             sync_rst,
    input logic [WIDTH-1:0] pad_d,
    input logic [WIDTH-1:0] data_hi,
    input logic [WIDTH-1:0] data_lo
);

    localparam logic [WIDTH-1:0] INIT_WORD = {WIDTH{lvl_bit(LEVEL)}};

    logic       rst_any;
    logic [2:0] warm;
    logic       primed;

    assign rst_any = async_ctl | sync_rst;

    always_ff @(posedge clk or posedge async_ctl) begin
        if (async_ctl) begin
            warm <= 3'd0;
        end else if (sync_rst) begin
            warm <= 3'd0;
        end else if (warm != 3'd4) begin
            warm <= warm + 3'd1;
        end
    end

    // R4, R5
    level_async_chk: assert property (@(posedge clk) disable iff (sync_rst)
        async_ctl |-> (data_hi == INIT_WORD && data_lo == INIT_WORD));

    // R6
    async_wins_chk: assert property (@(negedge clk) disable iff (sync_rst && !async_ctl)
        async_ctl |-> (data_hi == INIT_WORD && data_lo == INIT_WORD));

    generate
        if (ALIGN == EDGE_RISE) begin : g_rise
            logic [2*WIDTH-1:0] snap;

            always_ff @(negedge clk) snap <= {data_hi, data_lo};
            always_ff @(posedge clk) primed <= 1'b1;

            // R1
            pair_hi_chk: assert property (@(posedge clk) disable iff (rst_any)
                (warm == 3'd4) |-> (data_hi == $past(pad_d, 2)));

            // R1
            pair_lo_chk: assert property (@(negedge clk) disable iff (rst_any)
                (warm == 3'd4) |-> (data_lo == $past(pad_d, 1)));

            // R3
            other_edge_chk: assert property (@(posedge clk) disable iff (rst_any)
                (warm == 3'd4) |-> ({data_hi, data_lo} == snap));

            // R7
            sync_level_chk: assert property (@(posedge clk) disable iff (async_ctl)
                (primed === 1'b1 && $past(sync_rst)) |->
                    (data_hi == INIT_WORD && data_lo == INIT_WORD));
        end else begin : g_fall
            logic [2*WIDTH-1:0] snap;

            always_ff @(posedge clk) snap <= {data_hi, data_lo};
            always_ff @(negedge clk) primed <= 1'b1;

            // R2
            pair_hi_chk: assert property (@(posedge clk) disable iff (rst_any)
                (warm == 3'd4) |-> (data_hi == $past(pad_d, 2)));

            // R2
            pair_lo_chk: assert property (@(negedge clk) disable iff (rst_any)
                (warm == 3'd4) |-> (data_lo == $past(pad_d, 2)));

            // R3
            other_edge_chk: assert property (@(negedge clk) disable iff (rst_any)
                (warm == 3'd4) |-> ({data_hi, data_lo} == snap));

            // R7
            sync_level_chk: assert property (@(negedge clk) disable iff (async_ctl)
                (primed === 1'b1 && $past(sync_rst)) |->
                    (data_hi == INIT_WORD && data_lo == INIT_WORD));
        end
    endgenerate

endmodule

bind ddr_in_capture ddr_in_capture_chk #(
    .WIDTH (WIDTH),
    .LEVEL (LEVEL),
    .ALIGN (ALIGN)
) u_chk (
    .clk       (clk),
    .async_ctl (async_ctl),
    .sync_rst  (sync_rst),
    .pad_d     (pad_d),
    .data_hi   (data_hi),
    .data_lo   (data_lo)
);

// File: tb/tb_ddr_in_capture.sv
`timescale 1ns/100ps
module tb_ddr_in_capture;

    localparam int W = 4;
    localparam int N = 10;

    logic         clk = 1'b0;
    logic         async_ctl = 1'b0;
    logic         sync_rst = 1'b1;
    logic [W-1:0] pad_d = '0;
    logic [W-1:0] r_hi, r_lo, f_hi, f_lo;

    logic [W-1:0] seq_a [0:15];
    logic [W-1:0] seq_b [0:15];

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    // rising alignment, power-up low
    ddr_in_capture #(.WIDTH(W)) dut (
        .clk(clk), .async_ctl(async_ctl), .sync_rst(sync_rst),
        .pad_d(pad_d), .data_hi(r_hi), .data_lo(r_lo));

    // falling alignment, power-up high
    ddr_in_capture #(.WIDTH(W), .LEVEL(ddr_cap_pkg::LVL_HIGH),
                     .ALIGN(ddr_cap_pkg::EDGE_FALL)) dut_fall (
        .clk(clk), .async_ctl(async_ctl), .sync_rst(sync_rst),
        .pad_d(pad_d), .data_hi(f_hi), .data_lo(f_lo));

    task automatic chk(input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Entered and left 1 ns after a falling edge.
    task automatic run_stream(input int n);
        for (int k = 0; k < n; k++) begin
            pad_d = seq_a[k];
            @(posedge clk); #1;
            if (k > 0) chk("R1 rise pair", {r_hi, r_lo}, {seq_a[k-1], seq_b[k-1]});
            if (k > 1) chk("R3 fall stable", {f_hi, f_lo}, {seq_a[k-2], seq_b[k-2]});
            pad_d = seq_b[k];
            @(negedge clk); #1;
            if (k > 0) chk("R2 fall pair", {f_hi, f_lo}, {seq_a[k-1], seq_b[k-1]});
            if (k > 0) chk("R3 rise stable", {r_hi, r_lo}, {seq_a[k-1], seq_b[k-1]});
        end
    endtask

    task automatic scen_count();
        for (int k = 0; k < 16; k++) begin
            seq_a[k] = W'(k);
            seq_b[k] = ~W'(k);
        end
        run_stream(N);
    endtask

    task automatic scen_toggle();
        for (int k = 0; k < 16; k++) begin
            seq_a[k] = (k % 2 == 0) ? 4'hF : 4'h3;
            seq_b[k] = (k % 2 == 0) ? 4'h0 : 4'hC;
        end
        run_stream(N);
    endtask

    task automatic scen_walk();
        for (int k = 0; k < 16; k++) begin
            seq_a[k] = 4'b0001 << (k % 4);
            seq_b[k] = 4'b1000 >> (k % 4);
        end
        run_stream(N);
    endtask

    // Entered after scen_count: both copies show the pair (8, 7).
    task automatic scen_sync();
        sync_rst = 1'b1;
        pad_d = 4'h5;
        #0.5;
        chk("R7 rise before edge", {r_hi, r_lo}, 8'h87);
        chk("R7 fall before edge", {f_hi, f_lo}, 8'h87);
        @(posedge clk); #1;
        chk("R7 rise at edge", {r_hi, r_lo}, 8'h00);
        @(negedge clk); #1;
        chk("R7 fall at edge", {f_hi, f_lo}, 8'hFF);
        pad_d = 4'hA;
        @(posedge clk); #1;
        chk("R7 rise held", {r_hi, r_lo}, 8'h00);
        @(negedge clk); #1;
        chk("R7 fall held", {f_hi, f_lo}, 8'hFF);
        sync_rst = 1'b0;
    endtask

    task automatic scen_async();
        pad_d = 4'h9;
        @(posedge clk); #1;
        #0.5 async_ctl = 1'b1;
        #0.3;
        chk("R4 clear without edge", {r_hi, r_lo}, 8'h00);
        chk("R5 preset without edge", {f_hi, f_lo}, 8'hFF);
        pad_d = 4'h6;
        @(negedge clk); #1;
        chk("R6 rise over data", {r_hi, r_lo}, 8'h00);
        chk("R6 fall over data", {f_hi, f_lo}, 8'hFF);
        sync_rst = 1'b1;
        pad_d = 4'hF;
        @(posedge clk); #1;
        chk("R6 rise over sync", {r_hi, r_lo}, 8'h00);
        pad_d = 4'h0;
        @(negedge clk); #1;
        chk("R6 fall over sync", {f_hi, f_lo}, 8'hFF);
        sync_rst = 1'b0;
        @(posedge clk); #1;
        chk("R6 rise still held", {r_hi, r_lo}, 8'h00);
        @(negedge clk); #1;
        chk("R6 fall still held", {f_hi, f_lo}, 8'hFF);
        async_ctl = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) @(negedge clk);
        #1;
        chk("R7 reset state rise", {r_hi, r_lo}, 8'h00);
        chk("R7 reset state fall", {f_hi, f_lo}, 8'hFF);
        sync_rst = 1'b0;
        scen_count();
        scen_sync();
        scen_toggle();
        scen_async();
        scen_walk();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule